// File: doc/BRIEF.md
# Memory Write Protection Guard

This block sits on the write path of a 32K-word memory. Every write strobe is checked in the same cycle against a set of protection bits. A write to a protected region is stopped before it reaches the memory, and a violation interrupt is raised. The check applies in the same way to processor stores and to I/O channel writes. Reads are never gated.

Protection is not uniform across the memory. The lowest 2048 words are split into four 512-word sub-blocks. Every other region is a whole 2048-word block. That gives 19 protection bits. The bits come either from a lock register that software loads or from a bank of manual switches, and a mode input picks the source.

The first violating write is remembered: its address, its source, and a pending interrupt request that carries a fixed vector. The held copy stays unchanged until the request is acknowledged.

Top module: `wlk_guard`

## Requirements
- R1: Each address maps to exactly one protection bit:
  - an address below 2048 maps to bit `addr[10:9]` (bits 0 to 3, bit 0 covering words 0 to 511);
  - any other address maps to bit `3 + addr[14:11]` (bits 4 to 18).
- R2: `mem_we` is driven combinationally. It equals `wr_req` when the mapped bit is clear and is 0 when the mapped bit is set, in the same cycle as the request.
- R3: `mem_re` always equals `rd_req`. A read, whatever the protection state, never raises `irq` and never changes the held address.
- R4: The lock register resets to all zeros, so every write is allowed. When `lock_ld` is 1 it takes `lock_din` at the next edge; otherwise it holds its value.
- R5: When `manual_mode` is 1, the protection bits come from `manual_sw` instead of the lock register, using the same bit mapping as R1.
- R6: A blocked write sets `irq` on the next cycle. While `irq` is 1, `irq_vec` reads 29 (octal 35); while `irq` is 0, it reads 0.
- R7: The address and source (`wr_src`: 0 = processor, 1 = I/O channel) of the first blocked write are held in `viol_addr` and `viol_src`. Later blocked writes do not overwrite them while `irq` is pending and not acknowledged.
- R8: `irq_ack` clears `irq` on the next cycle. If a blocked write arrives in the same cycle as the acknowledge, `irq` stays 1 and the new write's address and source are captured.
- R9: Writes tagged as I/O channel are blocked and reported exactly like processor writes.
- R10: After reset, `irq`, `viol_addr` and `viol_src` are 0.
- R11: When a lock load and a write occur in the same cycle, the write is checked against the lock value held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write strobe |
| wr_src | input | 1 | Write source, 0 processor, 1 I/O channel |
| wr_addr | input | 15 | Write word address |
| rd_req | input | 1 | Read strobe |
| lock_ld | input | 1 | Load strobe for the lock register |
| lock_din | input | 19 | New lock register value |
| manual_mode | input | 1 | 1 selects the manual switches as the protection source |
| manual_sw | input | 19 | Manual protection switches |
| irq_ack | input | 1 | Acknowledge of the violation interrupt |
| mem_we | output | 1 | Write enable to memory |
| mem_re | output | 1 | Read enable to memory |
| irq | output | 1 | Pending violation interrupt |
| irq_vec | output | 6 | Interrupt vector, 29 while pending |
| viol_addr | output | 15 | Held address of the first violating write |
| viol_src | output | 1 | Held source of the first violating write |

## Verification
The assertions check four things on every cycle:
- every address selects exactly one protection bit;
- a write enable never appears without a request;
- a blocked write always raises the request, and an acknowledge without a new violation always clears it;
- the held address stays stable while the request is pending.

Some behaviours need the bench's scenarios instead:
- the exact boundary addresses of the sub-blocks and full blocks;
- switching between register and switch protection;
- the same-cycle races of acknowledge against a new violation, and of a lock load against a write.

In these scenarios a reference model predicts each output cycle by cycle.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  typedef enum logic {SRC_CPU = 1'b0, SRC_IO = 1'b1} wr_src_e;
  localparam int unsigned PROT_VEC_DEF = 29; // octal 35
endpackage

// File: rtl/wlk_region_decode.sv
module wlk_region_decode #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned BLK_BITS = 11,
  parameter int unsigned SUB_BITS = 9,
  localparam int unsigned HI_W    = ADDR_W - BLK_BITS,
  localparam int unsigned MID_W   = BLK_BITS - SUB_BITS,
  localparam int unsigned NUM_SUB = 1 << MID_W,
  localparam int unsigned NUM_BLK = 1 << HI_W,
  localparam int unsigned MASK_W  = NUM_SUB + NUM_BLK - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MASK_W-1:0] region_oh
);
  logic [HI_W-1:0]  blk_idx;
  logic [MID_W-1:0] sub_idx;
  logic             in_low;

  assign blk_idx = addr[ADDR_W-1:BLK_BITS];
  assign sub_idx = addr[BLK_BITS-1:SUB_BITS];
  assign in_low  = (blk_idx == '0);

  // Lowest block: finer sub-block granularity
  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    assign region_oh[g] = in_low && (sub_idx == MID_W'(g));
  end

  // Remaining blocks: one bit each
  for (genvar b = 1; b < NUM_BLK; b++) begin : g_blk
    assign region_oh[NUM_SUB + b - 1] = (blk_idx == HI_W'(b));
  end
endmodule

// File: rtl/wlk_lock_store.sv
module wlk_lock_store #(
  parameter int unsigned MASK_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_ld,
  input  logic [MASK_W-1:0] lock_din,
  input  logic              manual_mode,
  input  logic [MASK_W-1:0] manual_sw,
  output logic [MASK_W-1:0] prot_mask
);
  logic [MASK_W-1:0] lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (lock_ld) lock_d = lock_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  assign prot_mask = manual_mode ? manual_sw : lock_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ld |=> $stable(lock_q)); // R4
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ld |=> (lock_q == $past(lock_din))); // R4
endmodule

// File: rtl/wlk_viol_latch.sv
module wlk_viol_latch #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned VEC_W  = 6,
  parameter int unsigned VEC    = wlk_pkg::PROT_VEC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_in,
  input  logic [ADDR_W-1:0] viol_addr_in,
  input  logic              viol_src_in,
  input  logic              irq_ack,
  output logic              irq,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [ADDR_W-1:0] held_addr,
  output logic              held_src
);
  logic              irq_q, irq_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              src_q, src_d;
  logic              capture;

  always_comb begin
    capture = viol_in && (!irq_q || irq_ack);
    irq_d   = viol_in || (irq_q && !irq_ack);
    addr_d  = addr_q;
    src_d   = src_q;
    if (capture) begin
      addr_d = viol_addr_in;
      src_d  = viol_src_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      addr_q <= addr_d;
      src_q  <= src_d;
    end
  end

  assign irq       = irq_q;
  assign irq_vec   = irq_q ? VEC_W'(VEC) : '0;
  assign held_addr = addr_q;
  assign held_src  = src_q;

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_in |=> irq_q); // R6
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_in && !irq_q) |=> (addr_q == $past(viol_addr_in))); // R7
  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> ($stable(addr_q) && $stable(src_q))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !viol_in) |=> !irq_q); // R8
endmodule

// File: rtl/wlk_guard.sv
module wlk_guard #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned BLK_BITS = 11,
  parameter int unsigned SUB_BITS = 9,
  parameter int unsigned VEC_W    = 6,
  parameter int unsigned VEC      = wlk_pkg::PROT_VEC_DEF,
  localparam int unsigned NUM_SUB = 1 << (BLK_BITS - SUB_BITS),
  localparam int unsigned NUM_BLK = 1 << (ADDR_W - BLK_BITS),
  localparam int unsigned MASK_W  = NUM_SUB + NUM_BLK - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_src,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_req,
  input  logic              lock_ld,
  input  logic [MASK_W-1:0] lock_din,
  input  logic              manual_mode,
  input  logic [MASK_W-1:0] manual_sw,
  input  logic              irq_ack,
  output logic              mem_we,
  output logic              mem_re,
  output logic              irq,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [ADDR_W-1:0] viol_addr,
  output logic              viol_src
);
  logic              rst_s1, rst_s2;
  logic [MASK_W-1:0] region_oh;
  logic [MASK_W-1:0] prot_mask;
  logic              hit;
  logic              viol;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  wlk_region_decode #(
    .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .SUB_BITS(SUB_BITS)
  ) u_decode (
    .addr(wr_addr), .region_oh(region_oh)
  );

  wlk_lock_store #(.MASK_W(MASK_W)) u_lock (
    .clk(clk), .rst_n(rst_s2), .lock_ld(lock_ld), .lock_din(lock_din),
    .manual_mode(manual_mode), .manual_sw(manual_sw), .prot_mask(prot_mask)
  );

  assign hit    = |(region_oh & prot_mask);
  assign viol   = wr_req & hit;
  assign mem_we = wr_req & ~hit;
  assign mem_re = rd_req;

  wlk_viol_latch #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC(VEC)) u_latch (
    .clk(clk), .rst_n(rst_s2), .viol_in(viol), .viol_addr_in(wr_addr),
    .viol_src_in(wr_src), .irq_ack(irq_ack), .irq(irq), .irq_vec(irq_vec),
    .held_addr(viol_addr), .held_src(viol_src)
  );

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot(region_oh)); // R1
  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_s2)
    mem_we |-> wr_req); // R2
  AST_BLOCK_RAISES: assert property (@(posedge clk) disable iff (!rst_s2)
    (wr_req && !mem_we) |=> irq); // R9
  AST_READ_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_s2)
    (rd_req && !wr_req && !irq) |=> !irq); // R3
endmodule

// File: tb/wlk_guard_bench.sv
module wlk_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 0, wr_src = 0, rd_req = 0, lock_ld = 0;
  logic        manual_mode = 0, irq_ack = 0;
  logic [14:0] wr_addr = '0;
  logic [18:0] lock_din = '0, manual_sw = '0;
  logic        mem_we, mem_re, irq, viol_src;
  logic [5:0]  irq_vec;
  logic [14:0] viol_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  wlk_guard u_wlk_guard (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_src(wr_src),
    .wr_addr(wr_addr), .rd_req(rd_req), .lock_ld(lock_ld),
    .lock_din(lock_din), .manual_mode(manual_mode), .manual_sw(manual_sw),
    .irq_ack(irq_ack), .mem_we(mem_we), .mem_re(mem_re), .irq(irq),
    .irq_vec(irq_vec), .viol_addr(viol_addr), .viol_src(viol_src)
  );

  typedef struct {int cyc; int req; int sel; logic [31:0] exp;} item_t;
  item_t q[$];
  int ncyc = 0;
  int checks = 0, errors = 0;
  logic [18:0] m_lock = '0;
  logic        m_irq = 0, m_src = 0;
  logic [14:0] m_addr = '0;
  logic        cur_man = 0;
  logic [18:0] cur_sw = '0;

  always @(posedge clk) ncyc++;

  function automatic logic [31:0] got(int sel);
    case (sel)
      0: return {31'b0, mem_we};
      1: return {31'b0, irq};
      2: return {26'b0, irq_vec};
      3: return {17'b0, viol_addr};
      4: return {31'b0, viol_src};
      default: return {31'b0, mem_re};
    endcase
  endfunction

  task automatic push(int c, int r, int s, logic [31:0] e);
    item_t it;
    it.cyc = c; it.req = r; it.sel = s; it.exp = e;
    q.push_back(it);
  endtask

  // Monitor: compare expected items at the falling edge of their cycle
  initial begin
    forever begin
      int i;
      @(negedge clk);
      i = 0;
      while (i < q.size()) begin
        if (q[i].cyc == ncyc) begin
          checks++;
          if (got(q[i].sel) !== q[i].exp) begin
            errors++;
            $display("FAIL R%0d output %0d actual %0h expected %0h at cycle %0d",
                     q[i].req, q[i].sel, got(q[i].sel), q[i].exp, ncyc);
          end
          q.delete(i);
        end else i++;
      end
    end
  end

  // Driver: applies one cycle of stimulus and predicts the results
  task automatic step(logic wr, logic rd, logic [14:0] a, logic s,
                      logic ack, logic ld, logic [18:0] ldv, int r);
    int  idx;
    logic prot, viol;
    @(posedge clk); #1;
    wr_req = wr; rd_req = rd; wr_addr = a; wr_src = s; irq_ack = ack;
    lock_ld = ld; lock_din = ldv; manual_mode = cur_man; manual_sw = cur_sw;
    idx  = (a < 2048) ? int'(a >> 9) : 3 + int'(a >> 11);
    prot = cur_man ? cur_sw[idx] : m_lock[idx];
    viol = wr && prot;
    push(ncyc, r, 0, {31'b0, wr && !prot});
    push(ncyc, r, 5, {31'b0, rd});
    if (viol && (!m_irq || ack)) begin m_addr = a; m_src = s; end
    m_irq = viol || (m_irq && !ack);
    if (ld) m_lock = ldv;
    push(ncyc + 1, r, 1, {31'b0, m_irq});
    push(ncyc + 1, r, 2, m_irq ? 32'd29 : 32'd0);
    push(ncyc + 1, r, 3, {17'b0, m_addr});
    push(ncyc + 1, r, 4, {31'b0, m_src});
  endtask

  task automatic wr_op(logic [14:0] a, logic s, int r);
    step(1, 0, a, s, 0, 0, '0, r);
  endtask

  task automatic ack_op(int r);
    step(0, 0, '0, 0, 1, 0, '0, r);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  localparam logic [18:0] LOCKV = 19'h40105; // bits 0, 2, 8, 18

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R10: state after reset
    #1;
    push(ncyc, 10, 1, 0); push(ncyc, 10, 3, 0); push(ncyc, 10, 4, 0);
    push(ncyc, 10, 2, 0);
    // R4: reset lock allows everything
    wr_op(15'd0, 0, 4); wr_op(15'd16383, 0, 4); wr_op(15'd32767, 1, 4);
    step(0, 0, '0, 0, 0, 1, LOCKV, 4);
    // R1: boundaries of unprotected regions
    wr_op(15'd512, 0, 1); wr_op(15'd1536, 0, 1); wr_op(15'd2047, 0, 1);
    wr_op(15'd2048, 0, 1); wr_op(15'd12288, 0, 1);
    // R2 and R6: blocked processor write
    wr_op(15'd511, 0, 2);
    // R7: second violation while pending keeps the first
    wr_op(15'd1024, 1, 7); wr_op(15'd1535, 0, 7);
    ack_op(8);                                  // R8
    step(0, 0, '0, 0, 0, 0, '0, 8);
    // R9: I/O channel write blocked and reported
    wr_op(15'd10240, 1, 9); wr_op(15'd12287, 0, 7);
    // R8: acknowledge racing a new violation
    step(1, 0, 15'd32767, 0, 1, 0, '0, 8);
    ack_op(8);
    // R3: read of protected region passes, no interrupt
    step(0, 1, 15'd0, 0, 0, 0, '0, 3);
    step(0, 1, 15'd10240, 0, 0, 0, '0, 3);
    // R5: manual switch source
    cur_man = 1; cur_sw = 19'h00002;
    wr_op(15'd600, 0, 5); wr_op(15'd0, 0, 5); wr_op(15'd32767, 0, 5);
    ack_op(5);
    cur_man = 0;
    wr_op(15'd600, 0, 5);
    // R11: load and write in one cycle use the old lock
    step(1, 0, 15'd100, 0, 0, 1, '0, 11);
    wr_op(15'd100, 0, 11);
    ack_op(11);
    step(0, 0, '0, 0, 0, 0, '0, 11);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 pending items actual %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule